// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is a watchdog timer built as one down-counter used in two stages. When software enables it, or sends a keep-alive ping, the counter loads a value derived from the first-stage preload and counts down on every input clock. When the first stage runs out, the block pulses a selectable interrupt and reloads with the second-stage value. When the second stage also runs out, the block can request a system reset and records that event in a sticky flag that survives until software clears it.

The 20-bit preloads are scaled into clock counts by a left shift. The slow scale shifts by 15 bits, which gives a period of roughly a millisecond per unit at a 33 MHz input clock. The fast scale shifts by 5 bits, which gives roughly a microsecond per unit. In free-running mode the watchdog starts stage one again after stage two expires. Otherwise it stops until software restarts it. Register decoding and the write-unlock sequence are handled outside this block, which sees only plain level and strobe inputs.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset the watchdog is idle (`running_o` low), in stage one (`stage_two_o` low), with the sticky flag clear and all pulse outputs low.
- R2: A rising edge of `en_i` loads V = preload << shift with `stage_two_o` low. The stage expires at the clock edge V+1 cycles after the loading edge.
- R3: The shift is 5 when `slow_scale_i` is 0 and 15 when it is 1.
- R4: At stage-one expiry the block enters stage two with the stage-two value. It pulses `irq_o` for `int_sel_i` = 0 and `smi_o` for `int_sel_i` = 2. It pulses neither for codes 1 and 3.
- R5: At stage-two expiry with `reboot_en_i` high, `reset_req_o` pulses and `prev_timeout_o` becomes 1. With `reboot_en_i` low, neither happens.
- R6: After stage-two expiry the block restarts stage one when `free_run_i` is high. Otherwise it stops, with `running_o` low and `stage_two_o` still high.
- R7: While enabled, `ping_i` reloads stage one from either stage, and it takes priority over an expiry in the same cycle. While disabled, a ping has no effect.
- R8: With `en_i` low the counter stops at the next edge and no expiry action occurs.
- R9: `prev_timeout_o` stays set until `flag_clr_i` is sampled high. A new timeout in the same cycle as a clear leaves the flag set.
- R10: The preload and the scale are sampled only when a stage loads. Changes during a stage do not alter that stage's length.
- R11: `irq_o`, `smi_o` and `reset_req_o` are single-cycle pulses, and `irq_o` and `smi_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Watchdog enable level |
| free_run_i | input | 1 | Restart stage one after stage-two expiry |
| slow_scale_i | input | 1 | 1 selects shift 15, 0 selects shift 5 |
| int_sel_i | input | 2 | Stage-one action: 0 IRQ, 2 SMI, 1/3 none |
| reboot_en_i | input | 1 | Allow reset request at stage-two expiry |
| preload1_i | input | 20 | Stage-one preload |
| preload2_i | input | 20 | Stage-two preload |
| ping_i | input | 1 | Keep-alive strobe |
| flag_clr_i | input | 1 | Clears the sticky timeout flag |
| irq_o | output | 1 | Stage-one interrupt pulse |
| smi_o | output | 1 | Stage-one system-management interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |
| prev_timeout_o | output | 1 | Sticky flag for a reset caused by timeout |
| running_o | output | 1 | Counter is active |
| stage_two_o | output | 1 | Current stage is two |

## Verification
The assertions assume that `ping_i` and `flag_clr_i` are synchronous to `clk` and that `int_sel_i` and `reboot_en_i` are stable at expiry edges. The stimulus changes every input only at the falling edge and holds the action selects constant for a whole run. Only the preload and scale change mid-stage, and that change is deliberate, to show that they are sampled at load time. The fast scale with small preloads keeps most runs short. A single slow-scale stage-two run covers the 15-bit shift.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      ACT_IRQ  = 2'd0,
      ACT_RSVD = 2'd1,
      ACT_SMI  = 2'd2,
      ACT_NONE = 2'd3
   } stage1_act_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int PRELOAD_W  = 20,
   parameter int SLOW_SHIFT = 15,
   parameter int FAST_SHIFT = 5,
   parameter int CNT_W      = PRELOAD_W + SLOW_SHIFT
) (
   input  logic [PRELOAD_W-1:0] preload_i,
   input  logic                 slow_i,
   output logic [CNT_W-1:0]     count_o
);
   logic [CNT_W-1:0] wide;

   generate
      if (SLOW_SHIFT < FAST_SHIFT) begin : g_bad
         $error("wdt_prescale: SLOW_SHIFT must not be below FAST_SHIFT");
      end
      if (CNT_W < PRELOAD_W + SLOW_SHIFT) begin : g_narrow
         $error("wdt_prescale: CNT_W too narrow for the slow shift");
      end
   endgenerate

   assign wide = CNT_W'(preload_i);

   generate
      if (SLOW_SHIFT == FAST_SHIFT) begin : g_single
         assign count_o = wide << SLOW_SHIFT;
      end else begin : g_dual
         assign count_o = slow_i ? (wide << SLOW_SHIFT) : (wide << FAST_SHIFT);
      end
   endgenerate
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int CNT_W = 35
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (dec_i && !load_i) |-> !zero_o); // R2
endmodule

// File: rtl/wdt_expiry_action.sv
module wdt_expiry_action
   import wdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        exp1_i,
   input  logic        exp2_i,
   input  logic [1:0]  int_sel_i,
   input  logic        reboot_en_i,
   input  logic        flag_clr_i,
   output logic        irq_o,
   output logic        smi_o,
   output logic        reset_req_o,
   output logic        prev_timeout_o
);
   stage1_act_e act;
   logic        fire_reset;

   assign act        = stage1_act_e'(int_sel_i);
   assign fire_reset = exp2_i && reboot_en_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_o          <= 1'b0;
         smi_o          <= 1'b0;
         reset_req_o    <= 1'b0;
         prev_timeout_o <= 1'b0;
      end else begin
         irq_o       <= exp1_i && (act == ACT_IRQ);
         smi_o       <= exp1_i && (act == ACT_SMI);
         reset_req_o <= fire_reset;
         if (fire_reset)      prev_timeout_o <= 1'b1;
         else if (flag_clr_i) prev_timeout_o <= 1'b0;
      end
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
      irq_o |=> !irq_o); // R11
   AST_IRQ_SMI_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(irq_o && smi_o)); // R11
   AST_REBOOT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (exp2_i && reboot_en_i) |=> (reset_req_o && prev_timeout_o)); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (prev_timeout_o && !flag_clr_i) |=> prev_timeout_o); // R9
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
   parameter int PRELOAD_W  = 20,
   parameter int SLOW_SHIFT = 15,
   parameter int FAST_SHIFT = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en_i,
   input  logic                 free_run_i,
   input  logic                 slow_scale_i,
   input  logic [1:0]           int_sel_i,
   input  logic                 reboot_en_i,
   input  logic [PRELOAD_W-1:0] preload1_i,
   input  logic [PRELOAD_W-1:0] preload2_i,
   input  logic                 ping_i,
   input  logic                 flag_clr_i,
   output logic                 irq_o,
   output logic                 smi_o,
   output logic                 reset_req_o,
   output logic                 prev_timeout_o,
   output logic                 running_o,
   output logic                 stage_two_o
);
   localparam int CNT_W = PRELOAD_W + SLOW_SHIFT;

   logic             en_q, running_q, stage2_q;
   logic             start, restart1, expire, exp1, exp2, load, dec, zero;
   logic [PRELOAD_W-1:0] sel_preload;
   logic [CNT_W-1:0]     load_val;

   assign start    = en_i && !en_q;
   assign restart1 = en_i && (start || ping_i);
   assign expire   = en_i && running_q && zero && !restart1;
   assign exp1     = expire && !stage2_q;
   assign exp2     = expire && stage2_q;
   assign load     = restart1 || exp1 || (exp2 && free_run_i);
   assign dec      = en_i && running_q && !zero && !load;
   assign sel_preload = exp1 ? preload2_i : preload1_i;

   wdt_prescale #(
      .PRELOAD_W (PRELOAD_W),
      .SLOW_SHIFT(SLOW_SHIFT),
      .FAST_SHIFT(FAST_SHIFT),
      .CNT_W     (CNT_W)
   ) u_scale (
      .preload_i(sel_preload),
      .slow_i   (slow_scale_i),
      .count_o  (load_val)
   );

   wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load),
      .load_val_i(load_val),
      .dec_i     (dec),
      .zero_o    (zero)
   );

   wdt_expiry_action u_act (
      .clk           (clk),
      .rst           (rst),
      .exp1_i        (exp1),
      .exp2_i        (exp2),
      .int_sel_i     (int_sel_i),
      .reboot_en_i   (reboot_en_i),
      .flag_clr_i    (flag_clr_i),
      .irq_o         (irq_o),
      .smi_o         (smi_o),
      .reset_req_o   (reset_req_o),
      .prev_timeout_o(prev_timeout_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q      <= 1'b0;
         running_q <= 1'b0;
         stage2_q  <= 1'b0;
      end else begin
         en_q <= en_i;
         if (!en_i) begin
            running_q <= 1'b0;
         end else if (restart1) begin
            running_q <= 1'b1;
            stage2_q  <= 1'b0;
         end else if (exp1) begin
            stage2_q  <= 1'b1;
         end else if (exp2) begin
            if (free_run_i) stage2_q  <= 1'b0;
            else            running_q <= 1'b0;
         end
      end
   end

   assign running_o   = running_q;
   assign stage_two_o = stage2_q;

   AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> !running_o); // R8
   AST_PING_RESTART: assert property (@(posedge clk) disable iff (rst)
      (en_i && ping_i) |=> (running_o && !stage_two_o)); // R7
   AST_IRQ_IN_STAGE_TWO: assert property (@(posedge clk) disable iff (rst)
      (irq_o || smi_o) |-> stage_two_o); // R4
   AST_NO_ACTION_IDLE: assert property (@(posedge clk) disable iff (rst)
      !running_o |=> !(irq_o || smi_o || reset_req_o)); // R8
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 0, free_run = 0, slow = 0, reboot = 0, ping = 0, clr = 0;
   logic [1:0]  isel = 2'd0;
   logic [19:0] pl1 = 20'd2, pl2 = 20'd1;
   logic        irq, smi, rreq, flag, running, stage2;

   int cyc = 0;
   int n_chk = 0, n_fail = 0;
   int q_cyc[$];
   int q_kind[$];
   bit done = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_two_stage dut (
      .clk(clk), .rst(rst), .en_i(en), .free_run_i(free_run),
      .slow_scale_i(slow), .int_sel_i(isel), .reboot_en_i(reboot),
      .preload1_i(pl1), .preload2_i(pl2), .ping_i(ping), .flag_clr_i(clr),
      .irq_o(irq), .smi_o(smi), .reset_req_o(rreq), .prev_timeout_o(flag),
      .running_o(running), .stage_two_o(stage2)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int at, input int kind);
      q_cyc.push_back(at);
      q_kind.push_back(kind);
   endtask

   // monitor: kind 0 = irq, 1 = smi, 2 = reset request
   always @(negedge clk) begin
      if (!rst) begin
         for (int k = 0; k < 3; k++) begin
            bit seen;
            seen = (k == 0) ? irq : (k == 1) ? smi : rreq;
            if (seen) begin
               if (q_cyc.size() == 0) begin
                  chk(0, "R4/R5", "unexpected pulse kind", k, -1);
               end else begin
                  int ec, ek;
                  ec = q_cyc.pop_front();
                  ek = q_kind.pop_front();
                  chk(ec == cyc, "R2", "pulse cycle", cyc, ec);
                  chk(ek == k, "R4", "pulse kind", k, ek);
               end
            end
         end
         chk(!(irq && smi), "R11", "irq and smi together", int'(irq & smi), 0);
      end
   end

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic start_run(output int c);
      en = 0;
      @(negedge clk);
      en = 1;
      c = cyc;
   endtask

   task automatic stop_run();
      en = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic queue_empty(input string req);
      chk(q_cyc.size() == 0, req, "missing expected pulses", q_cyc.size(), 0);
      q_cyc.delete();
      q_kind.delete();
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk(running == 0, "R1", "running after reset", running, 0);
      chk(stage2 == 0, "R1", "stage after reset", stage2, 0);
      chk(flag == 0, "R1", "flag after reset", flag, 0);
      chk({irq, smi, rreq} == 0, "R1", "pulses after reset", {irq, smi, rreq}, 0);

      // R2 R4 R5 R6: IRQ type, reboot on, one shot (V1 = 64, V2 = 32)
      isel = 2'd0; reboot = 1; free_run = 0;
      start_run(c);
      push(c + 66, 0); push(c + 99, 2);
      wait_to(c + 67);
      chk(stage2 == 1, "R4", "stage two after stage one expiry", stage2, 1);
      wait_to(c + 104);
      chk(running == 0, "R6", "stopped after stage two", running, 0);
      chk(stage2 == 1, "R6", "stage stays two when stopped", stage2, 1);
      chk(flag == 1, "R5", "flag set by reboot", flag, 1);
      queue_empty("R2");
      // R9 explicit clear
      clr = 1; @(negedge clk); clr = 0;
      chk(flag == 0, "R9", "flag cleared", flag, 0);
      stop_run();

      // R4 SMI, R6 free run, R9 set wins over clear
      isel = 2'd2; reboot = 1; free_run = 1;
      start_run(c);
      push(c + 66, 1); push(c + 99, 2); push(c + 164, 1);
      wait_to(c + 98);
      clr = 1;
      @(negedge clk);
      clr = 0;
      chk(flag == 1, "R9", "timeout beats clear", flag, 1);
      wait_to(c + 120);
      chk(running == 1, "R6", "free run restarted", running, 1);
      chk(flag == 1, "R9", "flag sticky", flag, 1);
      wait_to(c + 180);
      stop_run();
      wait_to(c + 230);
      queue_empty("R6");
      chk(running == 0, "R8", "stopped by disable", running, 0);
      clr = 1; @(negedge clk); clr = 0;

      // R4 codes 1 and 3 give no pulse, R5 no reboot gives no request
      for (int t = 0; t < 2; t++) begin
         isel = (t == 0) ? 2'd1 : 2'd3; reboot = 0; free_run = 0;
         start_run(c);
         wait_to(c + 110);
         chk(running == 0, "R5", "stopped without reboot", running, 0);
         chk(flag == 0, "R5", "no flag without reboot", flag, 0);
         queue_empty("R4");
         stop_run();
      end

      // R7 ping in stage one and in stage two
      isel = 2'd0; reboot = 1; free_run = 0;
      start_run(c);
      wait_to(c + 40);
      ping = 1; @(negedge clk); ping = 0;
      push(c + 106, 0);
      wait_to(c + 120);
      chk(stage2 == 1, "R7", "stage two after delayed expiry", stage2, 1);
      ping = 1; @(negedge clk); ping = 0;
      chk(stage2 == 0, "R7", "ping returns to stage one", stage2, 0);
      push(c + 186, 0); push(c + 219, 2);
      wait_to(c + 225);
      queue_empty("R7");
      clr = 1; @(negedge clk); clr = 0;

      // R7 ping ignored while disabled
      stop_run();
      ping = 1; @(negedge clk); ping = 0;
      repeat (3) @(negedge clk);
      chk(running == 0, "R7", "ping while disabled", running, 0);

      // R8 disable mid stage one
      start_run(c);
      wait_to(c + 30);
      en = 0;
      wait_to(c + 120);
      chk(running == 0, "R8", "disable stops count", running, 0);
      queue_empty("R8");

      // R10 sampling at load, R3 slow scale in stage two
      isel = 2'd0; reboot = 1; free_run = 0; slow = 0; pl1 = 20'd2; pl2 = 20'd1;
      start_run(c);
      wait_to(c + 10);
      pl1 = 20'd8; slow = 1;
      push(c + 66, 0); push(c + 66 + 32769, 2);
      wait_to(c + 66 + 32775);
      chk(running == 0, "R3", "slow stage finished", running, 0);
      queue_empty("R10");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule